// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one copy engine that moves a counted run of items from a source address range to a destination address range over a single memory port. Software loads a few control registers through a plain write/select port and then pulses a start input. The channel runs in one of two modes. In register mode it copies one buffer described entirely by the registers. In chain mode it walks a linked list of five-word descriptors held in memory.

In chain mode the channel writes a completion word back into each descriptor when its buffer is finished. It then parks until software gives a keep-on pulse, which lets software refill or inspect buffers between links. The chain ends on the first descriptor whose second control word marks both descriptor-disable bits. At that point the channel signals chain completion and switches itself off.

The memory port is a valid/ready request channel followed by a response. A request stays valid, with address, direction, size and write data held stable, until the memory raises ready. Only one access is outstanding at a time. The response carries read data and an error flag and must arrive no earlier than the cycle after the request was accepted. The channel always accepts a response, so the response path has no back-pressure. A hold input stalls the channel between accesses, and a peripheral request line paces the data in any mode that involves a peripheral.

Top module: `dmal_channel`

## Requirements
- R1: After reset, `busy` is low, no memory request is valid, and all five registers read back zero. The register select codes are 0 source address, 1 destination address, 2 link pointer, 3 control A, 4 control B.
- R2: If control B bits 4 and 5 are both set when `ch_enable` pulses, the channel runs register mode. It copies the number of items given by control A bits [11:0], from the source register address to the destination register address, and fetches no descriptor. It then pulses `buf_done` and `chain_done` together for one cycle and drops `busy`.
- R3: When a buffer finishes, control A reads back with its count field [11:0] at zero and bit 31 (done) set. The other fields are unchanged.
- R4: Control A bits [13:12] give the source width and bits [15:14] give the destination width: 0 byte, 1 halfword, 2 word. Each item is read at source width and written at destination width, zero-extended or truncated. The count is in source items.
- R5: After each item, each address advances by its own width in bytes. Control B bit 0 keeps the source address fixed and bit 1 keeps the destination address fixed.
- R6: A count of zero completes the buffer with no data access at all.
- R7: If either disable bit is clear at start, the channel reads a five-word descriptor at the link pointer: source at offset 0, destination at 4, control A at 8, control B at 12, next pointer at 16. The link pointer register takes the next pointer. The chain ends after the first descriptor whose control B has bits 4 and 5 both set.
- R8: After each chained buffer, the completed control A word (count zero, bit 31 set) is written to offset 8 of that descriptor before `buf_done` pulses.
- R9: After a non-final chained buffer, the channel stays busy and issues no memory request until `keep_on` pulses. It then fetches from the link pointer. `chain_done` pulses only after the final buffer.
- R10: An error response on any access pulses `err_evt`, drops `busy`, and raises neither `buf_done` nor `chain_done`.
- R11: A request stays valid, with address, direction, size and data stable, until `mem_req_ready`. While `hold` is high, no new request starts.
- R12: Control B bits [3:2] select the flow mode: 0 memory to memory, 1 memory to peripheral, 2 peripheral to memory, 3 peripheral to peripheral. In modes 1 to 3, each chunk waits for `periph_req`. A chunk is CHUNK_BIG items when its chunk bit is set, and 1 item otherwise. Control A bit 16 is the chunk bit in modes 2 and 3, and bit 17 is the chunk bit in mode 1.
- R13: While `busy` is high, register writes and `ch_enable` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read-back |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| ch_enable | input | 1 | Start pulse |
| keep_on | input | 1 | Resume pulse for a parked chain |
| hold | input | 1 | Blocks new memory requests while high |
| periph_req | input | 1 | Peripheral request that paces chunks |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_size | output | 2 | Access width: 0 byte, 1 halfword, 2 word |
| mem_req_wdata | output | 32 | Right-justified write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | 32 | Right-justified read data |
| mem_rsp_err | input | 1 | Error flag of the response |
| busy | output | 1 | Channel enabled |
| buf_done | output | 1 | One-cycle buffer completion pulse |
| chain_done | output | 1 | One-cycle pulse when the channel finishes and disables itself |
| err_evt | output | 1 | One-cycle error pulse |

## Verification
The bench builds the channel with a 32-bit address and a large chunk of 4 items. A six-item paced transfer therefore splits into a full chunk and a short tail. Stopping the peripheral request after the first write shows the whole four-item chunk still completing before the channel waits again. The memory model lowers ready one cycle in four, so requests are held under back-pressure throughout. It answers with an error for any address above 4 KiB, which brings the error path within reach with an ordinary register value.

// File: rtl/dmal_pkg.sv
package dmal_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;

  // control A field positions
  localparam int CA_SW_LSB = 12;
  localparam int CA_DW_LSB = 14;
  localparam int CA_SCH    = 16;
  localparam int CA_DCH    = 17;
  localparam int CA_DONE   = 31;

  // control B field positions
  localparam int CB_SFIX     = 0;
  localparam int CB_DFIX     = 1;
  localparam int CB_FLOW_LSB = 2;
  localparam int CB_SDIS     = 4;
  localparam int CB_DDIS     = 5;

  // register select codes
  localparam logic [2:0] RS_SRC  = 3'd0;
  localparam logic [2:0] RS_DST  = 3'd1;
  localparam logic [2:0] RS_LINK = 3'd2;
  localparam logic [2:0] RS_CTLA = 3'd3;
  localparam logic [2:0] RS_CTLB = 3'd4;

  typedef enum logic [1:0] {FL_M2M = 2'd0, FL_M2P = 2'd1, FL_P2M = 2'd2, FL_P2P = 2'd3} flow_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_BUF_START, ST_GATE, ST_RD, ST_WR,
    ST_BUF_END, ST_WBACK, ST_PARK
  } state_e;

  typedef enum logic [1:0] {BP_IDLE, BP_REQ, BP_WAIT} bp_state_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] w);
    case (w)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dmal_addr_unit.sv
module dmal_addr_unit
  import dmal_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] seed,
  input  logic              step,
  input  logic              fixed,
  input  logic [1:0]        width,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= seed;
    end else if (step && !fixed) begin
      addr_q <= addr_q + ADDR_W'(width_bytes(width));
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/dmal_lane_fmt.sv
module dmal_lane_fmt
  import dmal_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  input  logic [1:0]        width,
  output logic [WORD_W-1:0] dout
);

  assign dout = din & width_mask(width);

endmodule

// File: rtl/dmal_bus_port.sv
module dmal_bus_port
  import dmal_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [1:0]        go_size,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              done,
  output logic              err
);

  bp_state_e         st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BP_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        BP_IDLE: if (go) begin
          st_q    <= BP_REQ;
          we_q    <= go_write;
          addr_q  <= go_addr;
          size_q  <= go_size;
          wdata_q <= go_wdata;
        end
        BP_REQ:  if (mem_req_ready) st_q <= BP_WAIT;
        BP_WAIT: if (mem_rsp_valid) st_q <= BP_IDLE;
        default: st_q <= BP_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st_q == BP_REQ);
  assign mem_req_write = we_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = size_q;
  assign mem_req_wdata = wdata_q;
  assign done          = (st_q == BP_WAIT) && mem_rsp_valid;
  assign err           = mem_rsp_err;

endmodule

// File: rtl/dmal_channel.sv
module dmal_channel
  import dmal_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CHUNK_BIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ch_enable,
  input  logic              keep_on,
  input  logic              hold,
  input  logic              periph_req,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic              busy,
  output logic              buf_done,
  output logic              chain_done,
  output logic              err_evt
);

  localparam int CHK_W = $clog2(CHUNK_BIG + 1);
  localparam int NDESC = 5;
  localparam int IDX_W = $clog2(NDESC);
  localparam logic [ADDR_W-1:0] CTLA_OFS = ADDR_W'(8);

  state_e              state_q;
  logic [ADDR_W-1:0]   src_q, dst_q, link_q, cur_desc_q;
  logic [WORD_W-1:0]   ctla_q, ctlb_q, data_q;
  logic [IDX_W-1:0]    idx_q;
  logic [CNT_W-1:0]    remain_q;
  logic [CHK_W-1:0]    chunk_q;
  logic                pend_q, single_q;
  logic                buf_done_q, chain_done_q, err_q;

  // decoded control fields
  logic [1:0] sw, dw;
  flow_e      flow;
  logic       both_dis, chunk_big_sel;
  assign sw       = ctla_q[CA_SW_LSB +: 2];
  assign dw       = ctla_q[CA_DW_LSB +: 2];
  assign flow     = flow_e'(ctlb_q[CB_FLOW_LSB +: 2]);
  assign both_dis = ctlb_q[CB_SDIS] && ctlb_q[CB_DDIS];
  assign chunk_big_sel = (flow == FL_M2P) ? ctla_q[CA_DCH] : ctla_q[CA_SCH];

  // bus port
  logic              bus_go, bus_we, bus_done, bus_err;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [WORD_W-1:0] bus_wdata, fmt_data;

  dmal_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (bus_go),
    .go_write      (bus_we),
    .go_addr       (bus_addr),
    .go_size       (bus_size),
    .go_wdata      (bus_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_size  (mem_req_size),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .done          (bus_done),
    .err           (bus_err)
  );

  dmal_lane_fmt u_fmt (
    .din   (data_q),
    .width (dw),
    .dout  (fmt_data)
  );

  // source (0) and destination (1) address walkers
  logic              au_load, au_step;
  logic [ADDR_W-1:0] au_seed [2];
  logic [ADDR_W-1:0] au_addr [2];
  logic              au_fix  [2];
  logic [1:0]        au_w    [2];

  assign au_seed[0] = src_q;
  assign au_seed[1] = dst_q;
  assign au_fix[0]  = ctlb_q[CB_SFIX];
  assign au_fix[1]  = ctlb_q[CB_DFIX];
  assign au_w[0]    = sw;
  assign au_w[1]    = dw;
  assign au_load    = (state_q == ST_BUF_START);
  assign au_step    = (state_q == ST_WR) && bus_done && !bus_err;

  for (genvar g = 0; g < 2; g++) begin : g_au
    dmal_addr_unit #(.ADDR_W(ADDR_W)) u_au (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (au_load),
      .seed  (au_seed[g]),
      .step  (au_step),
      .fixed (au_fix[g]),
      .width (au_w[g]),
      .addr  (au_addr[g])
    );
  end

  // request issue
  logic can_issue;
  assign can_issue = !pend_q && !hold;

  always_comb begin
    bus_go    = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_size  = 2'd2;
    bus_wdata = '0;
    unique case (state_q)
      ST_FETCH: begin
        bus_go   = can_issue;
        bus_addr = cur_desc_q + (ADDR_W'(idx_q) << 2);
      end
      ST_RD: begin
        bus_go   = can_issue;
        bus_addr = au_addr[0];
        bus_size = sw;
      end
      ST_WR: begin
        bus_go    = can_issue;
        bus_we    = 1'b1;
        bus_addr  = au_addr[1];
        bus_size  = dw;
        bus_wdata = fmt_data;
      end
      ST_WBACK: begin
        bus_go    = can_issue;
        bus_we    = 1'b1;
        bus_addr  = cur_desc_q + CTLA_OFS;
        bus_wdata = ctla_q;
      end
      default: ;
    endcase
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      src_q        <= '0;
      dst_q        <= '0;
      link_q       <= '0;
      cur_desc_q   <= '0;
      ctla_q       <= '0;
      ctlb_q       <= '0;
      data_q       <= '0;
      idx_q        <= '0;
      remain_q     <= '0;
      chunk_q      <= '0;
      pend_q       <= 1'b0;
      single_q     <= 1'b0;
      buf_done_q   <= 1'b0;
      chain_done_q <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      buf_done_q   <= 1'b0;
      chain_done_q <= 1'b0;
      err_q        <= 1'b0;
      if (bus_go) pend_q <= 1'b1;
      if (bus_done) pend_q <= 1'b0;

      if (bus_done && bus_err) begin
        err_q   <= 1'b1;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (reg_we) begin
              case (reg_sel)
                RS_SRC:  src_q  <= ADDR_W'(reg_wdata);
                RS_DST:  dst_q  <= ADDR_W'(reg_wdata);
                RS_LINK: link_q <= ADDR_W'(reg_wdata);
                RS_CTLA: ctla_q <= reg_wdata;
                RS_CTLB: ctlb_q <= reg_wdata;
                default: ;
              endcase
            end else if (ch_enable) begin
              if (both_dis) begin
                single_q <= 1'b1;
                state_q  <= ST_BUF_START;
              end else begin
                single_q   <= 1'b0;
                cur_desc_q <= link_q;
                idx_q      <= '0;
                state_q    <= ST_FETCH;
              end
            end
          end
          ST_FETCH: if (bus_done) begin
            idx_q <= idx_q + 1'b1;
            case (idx_q)
              3'd0: src_q  <= ADDR_W'(mem_rsp_rdata);
              3'd1: dst_q  <= ADDR_W'(mem_rsp_rdata);
              3'd2: ctla_q <= mem_rsp_rdata;
              3'd3: ctlb_q <= mem_rsp_rdata;
              default: begin
                link_q  <= ADDR_W'(mem_rsp_rdata);
                state_q <= ST_BUF_START;
              end
            endcase
          end
          ST_BUF_START: begin
            remain_q <= ctla_q[CNT_W-1:0];
            state_q  <= (ctla_q[CNT_W-1:0] == '0) ? ST_BUF_END : ST_GATE;
          end
          ST_GATE: if (flow == FL_M2M || periph_req) begin
            chunk_q <= chunk_big_sel ? CHK_W'(CHUNK_BIG) : CHK_W'(1);
            state_q <= ST_RD;
          end
          ST_RD: if (bus_done) begin
            data_q  <= mem_rsp_rdata;
            state_q <= ST_WR;
          end
          ST_WR: if (bus_done) begin
            remain_q <= remain_q - 1'b1;
            chunk_q  <= chunk_q - 1'b1;
            if (remain_q == CNT_W'(1))     state_q <= ST_BUF_END;
            else if (chunk_q == CHK_W'(1)) state_q <= ST_GATE;
            else                           state_q <= ST_RD;
          end
          ST_BUF_END: begin
            ctla_q[CNT_W-1:0] <= remain_q;
            ctla_q[CA_DONE]   <= 1'b1;
            if (single_q) begin
              buf_done_q   <= 1'b1;
              chain_done_q <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              state_q <= ST_WBACK;
            end
          end
          ST_WBACK: if (bus_done) begin
            buf_done_q <= 1'b1;
            if (both_dis) begin
              chain_done_q <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              state_q <= ST_PARK;
            end
          end
          ST_PARK: if (keep_on) begin
            cur_desc_q <= link_q;
            idx_q      <= '0;
            state_q    <= ST_FETCH;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      RS_SRC:  reg_rdata = 32'(src_q);
      RS_DST:  reg_rdata = 32'(dst_q);
      RS_LINK: reg_rdata = 32'(link_q);
      RS_CTLA: reg_rdata = ctla_q;
      RS_CTLB: reg_rdata = ctlb_q;
      default: reg_rdata = '0;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign buf_done   = buf_done_q;
  assign chain_done = chain_done_q;
  assign err_evt    = err_q;

endmodule

// File: rtl/dmal_channel_chk.sv
module dmal_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              busy,
  input logic              buf_done,
  input logic              chain_done,
  input logic              err_evt,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic [31:0]       mem_req_wdata
);

  // R11: request held stable under back-pressure
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_size) && $stable(mem_req_wdata));

  // R11: hold blocks any new request
  a_r11_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !mem_req_valid |=> !mem_req_valid);

  // R2: no memory traffic while the channel is off
  a_r2_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  // R10: error stops the channel without completion events
  a_r10_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !busy && !buf_done && !chain_done);

  // R9: chain completion comes with the last buffer and disables the channel
  a_r9_chain_end: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> buf_done && !busy);

endmodule

bind dmal_channel dmal_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hold          (hold),
  .busy          (busy),
  .buf_done      (buf_done),
  .chain_done    (chain_done),
  .err_evt       (err_evt),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/dmal_channel_tb.sv
`timescale 1ns/1ps
module dmal_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ch_enable = 1'b0, keep_on = 1'b0, hold = 1'b0, periph_req = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        busy, buf_done, chain_done, err_evt;

  always #4 clk = ~clk;

  dmal_channel #(.ADDR_W(32), .CHUNK_BIG(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_enable(ch_enable),
    .keep_on(keep_on), .hold(hold), .periph_req(periph_req),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err), .busy(busy), .buf_done(buf_done),
    .chain_done(chain_done), .err_evt(err_evt)
  );

  int checks = 0, errors = 0;
  int req_cnt = 0, wr_cnt = 0, buf_cnt = 0, chain_cnt = 0, err_cnt = 0, cyc = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] rdy_ctr = '0;

  assign mem_req_ready = (rdy_ctr[1:0] != 2'b11);

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  // memory model: one-cycle response, error above 4 KiB
  always @(posedge clk) begin
    logic [31:0] rd;
    int nb;
    rdy_ctr <= rdy_ctr + 8'd1;
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (buf_done)   buf_cnt   <= buf_cnt + 1;
    if (chain_done) chain_cnt <= chain_cnt + 1;
    if (err_evt)    err_cnt   <= err_cnt + 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      nb = 1 << mem_req_size;
      if (nb > 4) nb = 4;
      mem_rsp_valid <= 1'b1;
      if (mem_req_addr[31:12] != '0) begin
        mem_rsp_err   <= 1'b1;
        mem_rsp_rdata <= '0;
      end else if (mem_req_write) begin
        wr_cnt <= wr_cnt + 1;
        for (int b = 0; b < nb; b++) mem[mem_req_addr[11:0] + 12'(b)] <= mem_req_wdata[8*b +: 8];
      end else begin
        rd = '0;
        for (int b = 0; b < nb; b++) rd[8*b +: 8] = mem[mem_req_addr[11:0] + 12'(b)];
        mem_rsp_rdata <= rd;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  task automatic clr(input int a, input int n);
    for (int i = 0; i < n; i++) mem[a+i] = 8'h00;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                      input logic [31:0] a, input logic [31:0] b);
    wreg(3'd0, s); wreg(3'd1, d); wreg(3'd2, l); wreg(3'd3, a); wreg(3'd4, b);
  endtask

  task automatic pulse_en();
    @(negedge clk); ch_enable = 1'b1; @(negedge clk); ch_enable = 1'b0;
  endtask

  task automatic pulse_keep();
    @(negedge clk); keep_on = 1'b1; @(negedge clk); keep_on = 1'b0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 3000 && busy; g++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_buf(input int target);
    for (int g = 0; g < 3000 && buf_cnt < target; g++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mem_req_valid), 0);
    for (int s = 0; s < 5; s++) begin
      rreg(3'(s), v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_single_byte();
    int b0 = buf_cnt, c0 = chain_cnt;
    logic [31:0] v;
    clr(32'h400, 16);
    prog(32'h100, 32'h400, 0, 32'h5, 32'h30);
    pulse_en();
    wait_idle();
    for (int k = 0; k < 5; k++) chk("R2 data", 32'(mem[32'h400+k]), 32'(pat(32'h100+k)));
    chk("R2 beyond", 32'(mem[32'h405]), 0);
    chk("R2 buf_done", buf_cnt - b0, 1);
    chk("R2 chain_done", chain_cnt - c0, 1);
    rreg(3'd3, v);
    chk("R3 ctl_a done", v, 32'h8000_0000);
  endtask

  task automatic t_widths();
    clr(32'h500, 16);
    prog(32'h200, 32'h500, 0, 32'h9003, 32'h30);
    pulse_en();
    wait_idle();
    for (int k = 0; k < 3; k++)
      chk("R4 half to word", rd32(32'h500 + 4*k),
          {16'h0, pat(32'h201 + 2*k), pat(32'h200 + 2*k)});
    chk("R4 beyond", rd32(32'h50C), 0);
  endtask

  task automatic t_fixed_dst();
    clr(32'h600, 8);
    prog(32'h300, 32'h600, 0, 32'hA004, 32'h32);
    pulse_en();
    wait_idle();
    chk("R5 fixed dst last word", rd32(32'h600), rd32(32'h30C));
    chk("R5 fixed dst no step", rd32(32'h604), 0);
  endtask

  task automatic t_zero();
    int r0 = req_cnt, b0 = buf_cnt, c0 = chain_cnt;
    logic [31:0] v;
    prog(32'h100, 32'h400, 0, 32'h0, 32'h30);
    pulse_en();
    wait_idle();
    chk("R6 no access", req_cnt - r0, 0);
    chk("R6 buf_done", buf_cnt - b0, 1);
    chk("R6 chain_done", chain_cnt - c0, 1);
    rreg(3'd3, v);
    chk("R6 ctl_a", v, 32'h8000_0000);
  endtask

  task automatic t_chain();
    int b0 = buf_cnt, c0 = chain_cnt, r0;
    logic [31:0] v;
    clr(32'h700, 32);
    for (int i = 0; i < 3; i++) begin
      put32(32'h800 + 32*i,      32'h100 + 8*i);
      put32(32'h800 + 32*i + 4,  32'h700 + 8*i);
      put32(32'h800 + 32*i + 8,  32'h4);
      put32(32'h800 + 32*i + 12, (i == 2) ? 32'h30 : 32'h0);
      put32(32'h800 + 32*i + 16, (i == 2) ? 32'hABC0 : 32'h820 + 32*i);
    end
    prog(0, 0, 32'h800, 0, 32'h0);
    pulse_en();
    wait_buf(b0 + 1);
    r0 = req_cnt;
    repeat (30) @(negedge clk);
    chk("R9 parked busy", 32'(busy), 1);
    chk("R9 parked quiet", req_cnt - r0, 0);
    chk("R8 writeback 0", rd32(32'h808), 32'h8000_0000);
    chk("R9 no early chain_done", chain_cnt - c0, 0);
    rreg(3'd2, v);
    chk("R7 link advanced", v, 32'h820);
    wreg(3'd0, 32'hFFF);
    rreg(3'd0, v);
    chk("R13 write ignored", v, 32'h100);
    pulse_en();
    repeat (10) @(negedge clk);
    chk("R13 enable ignored", req_cnt - r0, 0);
    pulse_keep();
    wait_buf(b0 + 2);
    pulse_keep();
    wait_idle();
    chk("R7 buffers", buf_cnt - b0, 3);
    chk("R9 chain_done once", chain_cnt - c0, 1);
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < 4; k++)
        chk("R7 data", 32'(mem[32'h700 + 8*i + k]), 32'(pat(32'h100 + 8*i + k)));
      chk("R8 writeback", rd32(32'h808 + 32*i), 32'h8000_0000);
    end
    rreg(3'd2, v);
    chk("R7 final link", v, 32'hABC0);
  endtask

  task automatic t_error();
    int b0 = buf_cnt, c0 = chain_cnt, e0 = err_cnt;
    clr(32'h980, 4);
    prog(32'h0001_0000, 32'h980, 0, 32'h2, 32'h30);
    pulse_en();
    wait_idle();
    chk("R10 err_evt", err_cnt - e0, 1);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 no buf_done", buf_cnt - b0, 0);
    chk("R10 no chain_done", chain_cnt - c0, 0);
    chk("R10 dst untouched", 32'(mem[32'h980]), 0);
  endtask

  task automatic t_hold();
    int r0 = req_cnt;
    clr(32'h900, 4);
    prog(32'h1C0, 32'h900, 0, 32'h2, 32'h30);
    @(negedge clk); hold = 1'b1;
    pulse_en();
    repeat (20) @(negedge clk);
    chk("R11 hold quiet", req_cnt - r0, 0);
    chk("R11 hold busy", 32'(busy), 1);
    hold = 1'b0;
    wait_idle();
    chk("R11 after hold", 32'(mem[32'h901]), 32'(pat(32'h1C1)));
  endtask

  task automatic t_periph();
    int r0 = req_cnt, w0;
    clr(32'hA00, 8);
    prog(32'h180, 32'hA00, 0, 32'h10006, 32'h38);
    periph_req = 1'b0;
    pulse_en();
    repeat (20) @(negedge clk);
    chk("R12 waits for request", req_cnt - r0, 0);
    w0 = wr_cnt;
    periph_req = 1'b1;
    for (int g = 0; g < 500 && wr_cnt < w0 + 1; g++) @(negedge clk);
    periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R12 one chunk of four", wr_cnt - w0, 4);
    chk("R12 still busy", 32'(busy), 1);
    periph_req = 1'b1;
    wait_idle();
    periph_req = 1'b0;
    chk("R12 tail", wr_cnt - w0, 6);
    chk("R12 data", 32'(mem[32'hA05]), 32'(pat(32'h185)));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_widths();
    t_fixed_dst();
    t_zero();
    t_chain();
    t_error();
    t_hold();
    t_periph();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule